// File: doc/BRIEF.md
# Lane Register File for a Phased SIMT Core

This block is the private register storage of one thread lane in a small compute core that runs many lanes in lockstep. It holds sixteen 8-bit registers. The core steps every lane through the same repeating sequence of phases, and the lane's register file acts only in two of them. While the core is in its operand-gathering phase, the block reads two source registers and latches them onto its operand outputs, which feed the lane's arithmetic unit and memory unit. While the core is in its commit phase, it writes one destination register. The data for that write comes from the arithmetic result, from the memory result, or from an 8-bit constant carried in the instruction.

The instruction fields come in as the low twelve bits of the 16-bit instruction word. The destination index is in bits [11:8], the first source index in bits [7:4], and the second source index in bits [3:0]. The constant is bits [7:0]. A per-lane enable switches the whole lane off when the block of threads is narrower than the core. A disabled lane neither reads nor writes.

The 3-bit phase code is decoded into named phases:
- IDLE (000)
- FETCH (001)
- DECODE (010)
- REQUEST (011)
- WAIT (100)
- EXECUTE (101)
- UPDATE (110)
- DONE (111)

Only two transitions inside the block matter:
- Entering REQUEST with the lane enabled fires the operand capture.
- Entering UPDATE with the lane enabled and the write enable set fires the commit.

Every other phase holds all state.

Top module: `lane_regfile`

## Requirements
- R1: After reset, all sixteen registers and both operand outputs read as zero.
- R2: On a clock edge where the phase code is 011 (REQUEST) and the lane is enabled, `opnd_a` takes the register indexed by `instr_lo[7:4]` and `opnd_b` takes the register indexed by `instr_lo[3:0]`.
- R3: On a clock edge where the phase code is 110 (UPDATE), the lane is enabled, `rf_wr_en` is 1 and `wb_sel` is 00, the register indexed by `instr_lo[11:8]` takes `alu_res`.
- R4: Under the same commit conditions with `wb_sel` = 01, the destination takes `lsu_res`.
- R5: Under the same commit conditions with `wb_sel` = 10, the destination takes the constant `instr_lo[7:0]`.
- R6: With `wb_sel` = 11, no register changes, even in UPDATE with the write enable set.
- R7: With `rf_wr_en` low, no register changes in UPDATE.
- R8: In any phase code other than 110, no register changes, whatever `rf_wr_en` and `wb_sel` are.
- R9: While `lane_en` is low, no register is written and neither operand output changes, including in REQUEST and UPDATE.
- R10: Outside REQUEST, the operand outputs hold their last captured values.
- R11: All sixteen registers are distinct storage: each keeps its own value, and each can be read on either operand port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_en | input | 1 | Lane is active in the current thread block |
| core_phase | input | 3 | Shared core phase code |
| instr_lo | input | 12 | Instruction bits [11:0]: destination, source A, source B and constant fields |
| rf_wr_en | input | 1 | Decoded register write enable |
| wb_sel | input | 2 | Write-back source: 00 arithmetic, 01 memory, 10 constant, 11 none |
| alu_res | input | 8 | Arithmetic unit result |
| lsu_res | input | 8 | Load/store unit result |
| opnd_a | output | 8 | Captured first source operand |
| opnd_b | output | 8 | Captured second source operand |

## Verification
The bench tries every phase code except UPDATE with the write enable and a valid source select set. A decoder that keyed on the wrong code or on a single bit would corrupt a register, and a later read would show it. It tries select 11 and a disabled lane, where a mux that defaults to the arithmetic input, or an enable that gates only one path, would overwrite the destination or move an operand. It fills all sixteen registers with distinct values and reads them back in mirrored pairs, which exposes swapped field positions, aliased indices and a swapped operand port. It also walks the non-request phases after a capture, so a latch that follows its source combinationally shows up as a changed operand.

// File: rtl/lane_rf_pkg.sv
package lane_rf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'b000,
        PH_FETCH   = 3'b001,
        PH_DECODE  = 3'b010,
        PH_REQUEST = 3'b011,
        PH_WAIT    = 3'b100,
        PH_EXECUTE = 3'b101,
        PH_UPDATE  = 3'b110,
        PH_DONE    = 3'b111
    } core_phase_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'b00,
        WB_LSU  = 2'b01,
        WB_IMM  = 2'b10,
        WB_NONE = 2'b11
    } wb_src_e;

endpackage

// File: rtl/lane_rf_phase.sv
module lane_rf_phase
    import lane_rf_pkg::*;
(
    input  logic [2:0] phase_code,
    input  logic       lane_en,
    input  logic       wr_req,
    output logic       capture_go,
    output logic       commit_go
);

    core_phase_e phase;

    always_comb begin
        phase = core_phase_e'(phase_code);
    end

    // Phase-to-action decode: only REQUEST and UPDATE do anything.
    always_comb begin
        capture_go = 1'b0;
        commit_go  = 1'b0;
        unique case (phase)
            PH_IDLE:    ;
            PH_FETCH:   ;
            PH_DECODE:  ;
            PH_REQUEST: capture_go = lane_en;
            PH_WAIT:    ;
            PH_EXECUTE: ;
            PH_UPDATE:  commit_go  = lane_en & wr_req;
            PH_DONE:    ;
        endcase
    end

endmodule

// File: rtl/lane_rf_wbmux.sv
module lane_rf_wbmux
    import lane_rf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              commit_go,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [DATA_W-1:0] lsu_res,
    input  logic [DATA_W-1:0] imm,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data
);

    wb_src_e src;

    always_comb begin
        src = wb_src_e'(sel);
    end

    always_comb begin
        wr_data  = '0;
        wr_valid = 1'b0;
        unique case (src)
            WB_ALU: begin
                wr_data  = alu_res;
                wr_valid = commit_go;
            end
            WB_LSU: begin
                wr_data  = lsu_res;
                wr_valid = commit_go;
            end
            WB_IMM: begin
                wr_data  = imm;
                wr_valid = commit_go;
            end
            WB_NONE: begin
                wr_data  = '0;
                wr_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lane_rf_bank.sv
module lane_rf_bank #(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 16,
    localparam int ADDR_W   = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    logic [DATA_W-1:0] bank [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : gen_reg
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        logic [DATA_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_valid && (wr_addr == IDX)) begin
                q <= wr_data;
            end
        end

        assign bank[g] = q;
    end

    always_comb begin
        rd_data_a = bank[rd_addr_a];
        rd_data_b = bank[rd_addr_b];
    end

endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
    import lane_rf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int REG_COUNT  = 16,
    localparam int ADDR_W    = $clog2(REG_COUNT),
    localparam int FIELD_W   = 3 * ADDR_W,
    localparam int DST_LSB   = 2 * ADDR_W,
    localparam int SRCA_LSB  = ADDR_W,
    localparam int SRCB_LSB  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lane_en,
    input  logic [2:0]         core_phase,
    input  logic [FIELD_W-1:0] instr_lo,
    input  logic               rf_wr_en,
    input  logic [1:0]         wb_sel,
    input  logic [DATA_W-1:0]  alu_res,
    input  logic [DATA_W-1:0]  lsu_res,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b
);

    logic               capture_go;
    logic               commit_go;
    logic               wr_valid;
    logic [DATA_W-1:0]  wr_data;
    logic [DATA_W-1:0]  rd_a;
    logic [DATA_W-1:0]  rd_b;
    logic [ADDR_W-1:0]  dst_idx;
    logic [ADDR_W-1:0]  srca_idx;
    logic [ADDR_W-1:0]  srcb_idx;
    logic [DATA_W-1:0]  imm;

    always_comb begin
        dst_idx  = instr_lo[DST_LSB  +: ADDR_W];
        srca_idx = instr_lo[SRCA_LSB +: ADDR_W];
        srcb_idx = instr_lo[SRCB_LSB +: ADDR_W];
        imm      = instr_lo[DATA_W-1:0];
    end

    lane_rf_phase u_phase (
        .phase_code (core_phase),
        .lane_en    (lane_en),
        .wr_req     (rf_wr_en),
        .capture_go (capture_go),
        .commit_go  (commit_go)
    );

    lane_rf_wbmux #(.DATA_W(DATA_W)) u_wbmux (
        .commit_go (commit_go),
        .sel       (wb_sel),
        .alu_res   (alu_res),
        .lsu_res   (lsu_res),
        .imm       (imm),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data)
    );

    lane_rf_bank #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_addr   (dst_idx),
        .wr_data   (wr_data),
        .rd_addr_a (srca_idx),
        .rd_addr_b (srcb_idx),
        .rd_data_a (rd_a),
        .rd_data_b (rd_b)
    );

    // Operand latch: loads only on the request phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_a <= '0;
            opnd_b <= '0;
        end else if (capture_go) begin
            opnd_a <= rd_a;
            opnd_b <= rd_b;
        end
    end

endmodule

// File: rtl/lane_rf_checker.sv
module lane_rf_checker #(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               lane_en,
    input logic [2:0]         core_phase,
    input logic [FIELD_W-1:0] instr_lo,
    input logic               rf_wr_en,
    input logic [1:0]         wb_sel,
    input logic               wr_valid,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b
);

    // R2: equal source indices give equal operands one cycle later
    p_same_src_r2: assert property (@(posedge clk) disable iff (rst)
        (lane_en && core_phase == 3'b011 && instr_lo[7:4] == instr_lo[3:0])
        |=> (opnd_a == opnd_b));

    // R6
    p_sel_none_r6: assert property (@(posedge clk) disable iff (rst)
        (wb_sel == 2'b11) |-> !wr_valid);

    // R7, R8
    p_commit_phase_r8: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (core_phase == 3'b110 && lane_en && rf_wr_en));

    // R9
    p_lane_off_r9: assert property (@(posedge clk) disable iff (rst)
        !lane_en |=> ($stable(opnd_a) && $stable(opnd_b)));

    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (core_phase != 3'b011) |=> ($stable(opnd_a) && $stable(opnd_b)));

endmodule

bind lane_regfile lane_rf_checker #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lane_en    (lane_en),
    .core_phase (core_phase),
    .instr_lo   (instr_lo),
    .rf_wr_en   (rf_wr_en),
    .wb_sel     (wb_sel),
    .wr_valid   (wr_valid),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b)
);

// File: tb/sim_lane_regfile.sv
`timescale 1ns/1ps
module sim_lane_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        lane_en;
    logic [2:0]  core_phase;
    logic [11:0] instr_lo;
    logic        rf_wr_en;
    logic [1:0]  wb_sel;
    logic [7:0]  alu_res;
    logic [7:0]  lsu_res;
    logic [7:0]  opnd_a;
    logic [7:0]  opnd_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lane_regfile u0 (
        .clk(clk), .rst(rst), .lane_en(lane_en), .core_phase(core_phase),
        .instr_lo(instr_lo), .rf_wr_en(rf_wr_en), .wb_sel(wb_sel),
        .alu_res(alu_res), .lsu_res(lsu_res), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_idle();
        core_phase = 3'b000;
        rf_wr_en   = 1'b0;
        wb_sel     = 2'b00;
        instr_lo   = 12'h000;
    endtask

    // Drive one cycle in the given phase; called at a negedge, returns at the next negedge.
    task automatic cycle_write(input logic [2:0] ph, input logic [3:0] dst, input logic [1:0] sel,
                               input logic we, input logic [7:0] alu, input logic [7:0] lsu,
                               input logic [7:0] imm);
        core_phase = ph;
        instr_lo   = {dst, imm};
        wb_sel     = sel;
        rf_wr_en   = we;
        alu_res    = alu;
        lsu_res    = lsu;
        @(posedge clk);
        @(negedge clk);
        set_idle();
    endtask

    task automatic do_read(input logic [3:0] a, input logic [3:0] b);
        core_phase = 3'b011;
        instr_lo   = {4'h0, a, b};
        rf_wr_en   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        set_idle();
    endtask

    task automatic t_reset();
        check8("R1 opnd_a after reset", opnd_a, 8'h00);
        check8("R1 opnd_b after reset", opnd_b, 8'h00);
        do_read(4'd0, 4'd15);
        check8("R1 reg0", opnd_a, 8'h00);
        check8("R1 reg15", opnd_b, 8'h00);
    endtask

    task automatic t_sources();
        cycle_write(3'b110, 4'd3, 2'b00, 1'b1, 8'hA5, 8'h11, 8'h22);
        cycle_write(3'b110, 4'd4, 2'b01, 1'b1, 8'h11, 8'h3C, 8'h22);
        cycle_write(3'b110, 4'd5, 2'b10, 1'b1, 8'h11, 8'h22, 8'h7E);
        do_read(4'd3, 4'd4);
        check8("R3 alu write", opnd_a, 8'hA5);
        check8("R4 lsu write", opnd_b, 8'h3C);
        do_read(4'd5, 4'd3);
        check8("R5 immediate write", opnd_a, 8'h7E);
        check8("R2 port b routing", opnd_b, 8'hA5);
    endtask

    task automatic t_blocked();
        cycle_write(3'b110, 4'd3, 2'b11, 1'b1, 8'hFF, 8'hFF, 8'hFF);
        cycle_write(3'b110, 4'd4, 2'b00, 1'b0, 8'h00, 8'h00, 8'h00);
        for (int p = 0; p < 8; p++) begin
            if (p != 6) cycle_write(3'(p), 4'd5, 2'b00, 1'b1, 8'h00, 8'h00, 8'h00);
        end
        do_read(4'd3, 4'd4);
        check8("R6 select 11 no write", opnd_a, 8'hA5);
        check8("R7 write enable low", opnd_b, 8'h3C);
        do_read(4'd5, 4'd5);
        check8("R8 wrong phase no write", opnd_a, 8'h7E);
    endtask

    task automatic t_lane_off();
        do_read(4'd5, 4'd4);
        lane_en = 1'b0;
        cycle_write(3'b110, 4'd3, 2'b00, 1'b1, 8'h01, 8'h01, 8'h01);
        do_read(4'd3, 4'd3);
        check8("R9 lane off operand a held", opnd_a, 8'h7E);
        check8("R9 lane off operand b held", opnd_b, 8'h3C);
        lane_en = 1'b1;
        do_read(4'd3, 4'd3);
        check8("R9 lane off no write", opnd_a, 8'hA5);
    endtask

    task automatic t_hold();
        do_read(4'd4, 4'd5);
        for (int p = 0; p < 8; p++) begin
            if (p != 3) begin
                core_phase = 3'(p);
                instr_lo   = 12'h0FF;
                @(posedge clk);
                @(negedge clk);
            end
        end
        set_idle();
        check8("R10 hold operand a", opnd_a, 8'h3C);
        check8("R10 hold operand b", opnd_b, 8'h7E);
    endtask

    task automatic t_all_regs();
        for (int i = 0; i < 16; i++)
            cycle_write(3'b110, 4'(i), 2'b00, 1'b1, 8'(i * 17 + 3), 8'h00, 8'h00);
        for (int i = 0; i < 16; i++) begin
            do_read(4'(i), 4'(15 - i));
            check8("R11 distinct reg port a", opnd_a, 8'(i * 17 + 3));
            check8("R2 distinct reg port b", opnd_b, 8'((15 - i) * 17 + 3));
        end
    endtask

    initial begin
        rst     = 1'b1;
        lane_en = 1'b1;
        alu_res = 8'h00;
        lsu_res = 8'h00;
        set_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sources();
        t_blocked();
        t_lane_off();
        t_hold();
        t_all_regs();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #40000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule